// File: doc/BRIEF.md
# Two-Requester Arbiter Rule Monitor

This block watches the request and grant lines of a two-requester priority arbiter and flags, in hardware, every cycle in which the grants break the arbiter's temporal rules. The high-priority request must be granted for the two cycles after it is raised. The two grants must never be high together. The high-priority grant must never appear without a request that explains it. The monitor also warns when the request pattern is the one that makes these rules clash with an older, inconsistent rule set.

It keeps two cycles of high-priority request history, one cycle of low-priority request history, and a warm-up count of cycles since reset. A rule that looks back in time is only judged once enough history has been collected since reset. All outputs are registered. Each result appears in the cycle after the cycle it judges.

Top module: `arbmon_top`

## Requirements
- R1: While `rst` is high at a rising edge, every output (`viol_vec`, `err_sticky`, `viol_pulse`, `conflict_warn`) is 0 after that edge, and all history and the warm-up count are cleared.
- R2: `viol_vec[0]` (hold rule) is 1 in the cycle after cycle c exactly when `gnt_hi` is low in c while `req_hi` was high in c-1 or in c-2, counting only cycles after reset.
- R3: `viol_vec[1]` (mutual exclusion) is 1 in the cycle after cycle c exactly when `gnt_hi` and `gnt_lo` are both high in c.
- R4: `viol_vec[2]` (high grant forces low grant off) is 1 in the cycle after cycle c exactly when `gnt_lo` is high in a cycle c where `gnt_hi` is high. It is reported apart from bit 1 even though the condition matches.
- R5: `viol_vec[3]` (spurious grant) is 1 in the cycle after cycle c exactly when `gnt_hi` is high in c while `req_hi` was low in both c-1 and c-2.
- R6: No rule uses history from before reset. After a reset, the c-1 term is only used once one cycle has passed, and the c-2 terms (including all of bit 3) are only used once two cycles have passed.
- R7: `err_sticky` is the OR of every `viol_vec` bit seen since the last reset and stays high until reset.
- R8: `viol_pulse` is high for one cycle exactly when `viol_vec` holds a 1 in a bit that was 0 in the cycle before.
- R9: `conflict_warn` is 1 in the cycle after cycle c exactly when `req_hi` and `req_lo` are both low in c, `req_hi` was high in c-1 and `req_lo` was low in c-1, with c-1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_hi | input | 1 | High-priority request observed |
| req_lo | input | 1 | Low-priority request observed |
| gnt_hi | input | 1 | High-priority grant observed |
| gnt_lo | input | 1 | Low-priority grant observed |
| viol_vec | output | 4 | Per-rule violation of the previous cycle: bit0 hold, bit1 exclusion, bit2 high-grant-forces-low-off, bit3 spurious |
| err_sticky | output | 1 | Any violation since reset |
| viol_pulse | output | 1 | One-cycle event on a newly failing rule |
| conflict_warn | output | 1 | The conflict-prone request pattern just completed |

## Verification
Every output is one register away from the inputs it judges. A grant in cycle c is scored in the cycle after c, even when the request it is scored against lies one or two cycles further back. The bench drives inputs on the falling edge and keeps a reference model that it advances at the rising edge. At the next falling edge it compares each output bit against the model, so a request raised at t is judged against the grants of t+1 and t+2, with results visible in t+2 and t+3. Directed sequences right after reset exercise the warm-up window, in which stale history would otherwise raise bit 0 or bit 3.

// File: rtl/arbmon_pkg.sv
package arbmon_pkg;

    localparam int unsigned NUM_RULES = 4;
    localparam int unsigned HI_DEPTH  = 2;
    localparam int unsigned LO_DEPTH  = 1;
    localparam int unsigned WARM_MAX  = 2;
    localparam int unsigned WARM_W    = $clog2(WARM_MAX + 1);

    localparam int unsigned RULE_HOLD  = 0;
    localparam int unsigned RULE_MUTEX = 1;
    localparam int unsigned RULE_EXCL  = 2;
    localparam int unsigned RULE_SPUR  = 3;

    typedef logic [NUM_RULES-1:0] viol_t;

    typedef struct packed {
        logic req_hi;
        logic req_lo;
        logic gnt_hi;
        logic gnt_lo;
    } obs_t;

    typedef struct packed {
        logic [HI_DEPTH-1:0] hi;   // [0] = one cycle back, [1] = two cycles back
        logic [LO_DEPTH-1:0] lo;
        logic [WARM_W-1:0]   warm;
    } hist_t;

    function automatic logic aged(input logic [WARM_W-1:0] w, input int unsigned n);
        return 32'(w) >= n;
    endfunction

endpackage

// File: rtl/arbmon_history.sv
module arbmon_history
    import arbmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  obs_t  obs,
    output hist_t hist
);
    logic [HI_DEPTH-1:0] hi_q;
    logic [LO_DEPTH-1:0] lo_q;
    logic [WARM_W-1:0]   warm_q;

    always_ff @(posedge clk) begin
        if (rst) hi_q <= '0;
        else     hi_q <= {hi_q[HI_DEPTH-2:0], obs.req_hi};
    end

    generate
        if (LO_DEPTH == 1) begin : g_lo_single
            always_ff @(posedge clk) begin
                if (rst) lo_q <= '0;
                else     lo_q <= obs.req_lo;
            end
        end else begin : g_lo_chain
            always_ff @(posedge clk) begin
                if (rst) lo_q <= '0;
                else     lo_q <= {lo_q[LO_DEPTH-2:0], obs.req_lo};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            warm_q <= '0;
        else if (warm_q != WARM_MAX[WARM_W-1:0])
            warm_q <= warm_q + 1'b1;
    end

    always_comb begin
        hist.hi   = hi_q;
        hist.lo   = lo_q;
        hist.warm = warm_q;
    end
endmodule

// File: rtl/arbmon_rules.sv
module arbmon_rules
    import arbmon_pkg::*;
(
    input  obs_t  obs,
    input  hist_t hist,
    output viol_t flags,
    output logic  warn_now
);
    logic owed1, owed2, quiet2;

    always_comb begin
        owed1  = aged(hist.warm, 1) & hist.hi[0];
        owed2  = aged(hist.warm, 2) & hist.hi[1];
        quiet2 = aged(hist.warm, 2) & ~hist.hi[0] & ~hist.hi[1];

        flags             = '0;
        flags[RULE_HOLD]  = (owed1 | owed2) & ~obs.gnt_hi;
        flags[RULE_MUTEX] = obs.gnt_hi & obs.gnt_lo;
        flags[RULE_EXCL]  = obs.gnt_hi ? obs.gnt_lo : 1'b0;
        flags[RULE_SPUR]  = quiet2 & obs.gnt_hi;

        warn_now = aged(hist.warm, 1) & hist.hi[0] & ~hist.lo[0]
                 & ~obs.req_hi & ~obs.req_lo;
    end
endmodule

// File: rtl/arbmon_report.sv
module arbmon_report
    import arbmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  viol_t flags,
    input  logic  warn_now,
    output viol_t vec,
    output logic  err,
    output logic  pulse,
    output logic  warn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vec   <= '0;
            err   <= 1'b0;
            pulse <= 1'b0;
            warn  <= 1'b0;
        end else begin
            vec   <= flags;
            err   <= err | (|flags);
            pulse <= |(flags & ~vec);
            warn  <= warn_now;
        end
    end
endmodule

// File: rtl/arbmon_top.sv
module arbmon_top
    import arbmon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_hi,
    input  logic                 req_lo,
    input  logic                 gnt_hi,
    input  logic                 gnt_lo,
    output logic [NUM_RULES-1:0] viol_vec,
    output logic                 err_sticky,
    output logic                 viol_pulse,
    output logic                 conflict_warn
);
    obs_t  obs;
    hist_t hist;
    viol_t flags;
    logic  warn_now;

    always_comb begin
        obs.req_hi = req_hi;
        obs.req_lo = req_lo;
        obs.gnt_hi = gnt_hi;
        obs.gnt_lo = gnt_lo;
    end

    arbmon_history u_hist (
        .clk  (clk),
        .rst  (rst),
        .obs  (obs),
        .hist (hist)
    );

    arbmon_rules u_rules (
        .obs      (obs),
        .hist     (hist),
        .flags    (flags),
        .warn_now (warn_now)
    );

    arbmon_report u_rep (
        .clk      (clk),
        .rst      (rst),
        .flags    (flags),
        .warn_now (warn_now),
        .vec      (viol_vec),
        .err      (err_sticky),
        .pulse    (viol_pulse),
        .warn     (conflict_warn)
    );
endmodule

// File: rtl/arbmon_chk.sv
module arbmon_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_hi,
    input logic       req_lo,
    input logic       gnt_hi,
    input logic       gnt_lo,
    input logic [3:0] viol_vec,
    input logic       err_sticky,
    input logic       viol_pulse,
    input logic       conflict_warn
);
    logic [1:0] since;

    always_ff @(posedge clk) begin
        if (rst)              since <= 2'd0;
        else if (since != 2'd2) since <= since + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (viol_vec == 4'd0 && !err_sticky && !viol_pulse && !conflict_warn)); // R1

    AST_HOLD_MISS: assert property (@(posedge clk) disable iff (rst)
        (since >= 2'd1 && $past(req_hi) && !gnt_hi) |=> viol_vec[0]); // R2

    AST_MUTEX: assert property (@(posedge clk) disable iff (rst)
        (gnt_hi && gnt_lo) |=> viol_vec[1]); // R3

    AST_EXCL: assert property (@(posedge clk) disable iff (rst)
        (gnt_hi && gnt_lo) |=> viol_vec[2]); // R4

    AST_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd2 && !$past(req_hi) && !$past(req_hi, 2) && gnt_hi) |=> viol_vec[3]); // R5

    AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd0) |=> (!viol_vec[0] && !viol_vec[3])); // R6

    AST_STICKY_COVERS: assert property (@(posedge clk) disable iff (rst)
        (viol_vec != 4'd0) |-> err_sticky); // R7

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky); // R7

    AST_PULSE_NEW: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |-> ((viol_vec & ~$past(viol_vec)) != 4'd0)); // R8

    AST_WARN_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (since >= 2'd1 && $past(req_hi) && !$past(req_lo) && !req_hi && !req_lo) |=> conflict_warn); // R9
endmodule

bind arbmon_top arbmon_chk i_chk (.*);

// File: tb/test_arbmon_top.sv
`timescale 1ns/1ps
module test_arbmon_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_hi = 1'b0, req_lo = 1'b0, gnt_hi = 1'b0, gnt_lo = 1'b0;
    logic [3:0] viol_vec;
    logic err_sticky, viol_pulse, conflict_warn;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic       m_hi1 = 0, m_hi2 = 0, m_lo1 = 0;
    int         m_since = 0;
    logic [3:0] e_vec = 0;
    logic       e_err = 0, e_pulse = 0, e_warn = 0;

    always #4 clk = ~clk;

    arbmon_top i_arbmon_top (
        .clk(clk), .rst(rst), .req_hi(req_hi), .req_lo(req_lo),
        .gnt_hi(gnt_hi), .gnt_lo(gnt_lo), .viol_vec(viol_vec),
        .err_sticky(err_sticky), .viol_pulse(viol_pulse), .conflict_warn(conflict_warn)
    );

    function automatic logic [3:0] rule_flags(input logic r1p, r1pp, input int since,
                                              input logic g1, g2);
        logic [3:0] f;
        f[0] = (((since >= 1) && r1p) || ((since >= 2) && r1pp)) && !g1;
        f[1] = g1 && g2;
        f[2] = g1 && g2;
        f[3] = (since >= 2) && !r1p && !r1pp && g1;
        return f;
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge(input logic r, r1, r2, g1, g2);
        logic [3:0] f;
        if (r) begin
            m_hi1 = 0; m_hi2 = 0; m_lo1 = 0; m_since = 0;
            e_vec = 0; e_err = 0; e_pulse = 0; e_warn = 0;
        end else begin
            f       = rule_flags(m_hi1, m_hi2, m_since, g1, g2);
            e_pulse = |(f & ~e_vec);
            e_err   = e_err | (|f);
            e_vec   = f;
            e_warn  = (m_since >= 1) && m_hi1 && !m_lo1 && !r1 && !r2;
            m_hi2   = m_hi1; m_hi1 = r1; m_lo1 = r2;
            if (m_since < 2) m_since++;
        end
    endtask

    // called at a falling edge; drives, lets one rising edge pass, compares
    task automatic step(input logic r, r1, r2, g1, g2);
        rst = r; req_hi = r1; req_lo = r2; gnt_hi = g1; gnt_lo = g2;
        @(posedge clk);
        model_edge(r, r1, r2, g1, g2);
        @(negedge clk);
        chk("R2 hold bit",      {3'b0, viol_vec[0]}, {3'b0, e_vec[0]});
        chk("R3 mutex bit",     {3'b0, viol_vec[1]}, {3'b0, e_vec[1]});
        chk("R4 excl bit",      {3'b0, viol_vec[2]}, {3'b0, e_vec[2]});
        chk("R5 spurious bit",  {3'b0, viol_vec[3]}, {3'b0, e_vec[3]});
        chk("R7 sticky",        {3'b0, err_sticky},  {3'b0, e_err});
        chk("R8 pulse",         {3'b0, viol_pulse},  {3'b0, e_pulse});
        chk("R9 warn",          {3'b0, conflict_warn}, {3'b0, e_warn});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: got running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic p1, p2, gr1, gr2;
        void'($urandom(32'd20240607));
        @(negedge clk);
        // R1: reset with stale r1 history driven in
        step(1, 1, 0, 0, 0);
        step(1, 1, 1, 1, 1);
        chk("R1 reset vec", viol_vec, 4'h0);
        chk("R1 reset flags", {1'b0, err_sticky, viol_pulse, conflict_warn}, 4'h0);

        // R6: stale r1 must not raise hold; early g1 must not be spurious
        step(0, 0, 0, 1, 0);
        chk("R6 early hold", {3'b0, viol_vec[0]}, 4'h0);
        chk("R6 early spurious", {3'b0, viol_vec[3]}, 4'h0);
        step(0, 0, 0, 1, 0);
        chk("R6 second spurious", {3'b0, viol_vec[3]}, 4'h0);
        step(0, 0, 0, 1, 0);
        chk("R5 spurious after warm-up", {3'b0, viol_vec[3]}, 4'h1);

        // R2: request then grant held twice (clean), then a missed second cycle
        step(1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        chk("R2 clean hold", {3'b0, viol_vec[0]}, 4'h0);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0);
        chk("R2 missed second cycle", {3'b0, viol_vec[0]}, 4'h1);
        chk("R7 sticky after miss", {3'b0, err_sticky}, 4'h1);

        // R9: conflict-prone pattern
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        chk("R9 pattern warn", {3'b0, conflict_warn}, 4'h1);

        // R3 R4: both grants together, held so pulse fires once (R8)
        step(0, 1, 1, 1, 1);
        chk("R3 R4 both grants", viol_vec & 4'h6, 4'h6);
        chk("R8 pulse on new bits", {3'b0, viol_pulse}, 4'h1);
        step(0, 1, 1, 1, 1);
        chk("R8 no pulse on repeat", {3'b0, viol_pulse}, 4'h0);

        // random traffic: a mostly well-behaved arbiter with injected faults
        p1 = 0; p2 = 0;
        for (int i = 0; i < 4000; i++) begin
            logic r1, r2, g1, g2, rr;
            rr = ($urandom % 300) == 0;
            r1 = ($urandom % 3) == 0;
            r2 = ($urandom % 2) == 0;
            gr1 = p1 | p2;
            gr2 = r2 & ~gr1;
            g1 = (($urandom % 12) == 0) ? ~gr1 : gr1;
            g2 = (($urandom % 12) == 0) ? ~gr2 : gr2;
            step(rr, r1, r2, g1, g2);
            p2 = rr ? 1'b0 : p1;
            p1 = rr ? 1'b0 : r1;
        end

        // R1: reset after violations clears everything
        step(0, 0, 0, 1, 1);
        step(1, 0, 0, 0, 0);
        chk("R1 reset after faults vec", viol_vec, 4'h0);
        chk("R1 reset after faults flags", {1'b0, err_sticky, viol_pulse, conflict_warn}, 4'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule